// File: doc/BRIEF.md
# Comparator Edge Interrupt Controller

This block is the digital wrapper around an on-chip voltage comparator. The comparator's one-bit result enters as an asynchronous input. The block passes it through a synchronizer and shows the live level in an 8-bit control/status register. It watches the level for a selectable transition and keeps a sticky interrupt flag. It raises an interrupt request when the flag, the local enable and the global enable are all set. It can also steer the comparator level onto a trigger line that feeds a timer's input-capture stage.

Software sees one register. A write strobe with write data updates the control fields. The same write clears the flag when it carries a 1 in the flag position. The interrupt controller clears the flag with a single-cycle acknowledge strobe. The register read value is combinational from the block's state. There is no data stream in this block, so every pin is a plain control or status signal with no handshake.

Top module: `cmp_irq_ctrl`

## Requirements
- R1: After reset every writable field is 0, the flag is 0, `irq` is 0 and `cap_trig` is 0.
- R2: The read layout is: bit 7 disable, bit 6 reserved, bit 5 comparator level, bit 4 flag, bit 3 interrupt enable, bit 2 capture routing, bits 1:0 edge mode. Bit 6 always reads 0.
- R3: Bit 5 reads 1 when `cmp_in` is 1 (positive input above negative). It follows `cmp_in` two clock edges after the input changes, through a 2-flop synchronizer.
- R4: Edge mode 00 flags any change of the synchronized level, 10 flags only a 1-to-0 change and 11 flags only a 0-to-1 change. The flag reads 1 after the third rising clock edge that follows the input change.
- R5: Edge mode 01 is reserved and never sets the flag.
- R6: A write that has bit 4 = 1 clears the flag, whatever the other bits hold. A write with bit 4 = 0 leaves the flag unchanged. Software can never set the flag.
- R7: A one-cycle `int_ack` pulse clears the flag.
- R8: When an event and a clear (write-one or acknowledge) arrive in the same cycle, the flag is left set.
- R9: `irq` is 1 exactly when the flag, the interrupt enable (bit 3) and `gie` are all 1.
- R10: While capture routing (bit 2) is 1 and the block is enabled, `cap_trig` equals the synchronized level. Otherwise `cap_trig` is 0.
- R11: While disable (bit 7) is 1, bit 5 reads 0, no event sets the flag and `cap_trig` is 0. A flag that is already set stays set.
- R12: Writes to bits 6 and 5 have no effect on what those bits read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmp_in | input | 1 | Raw comparator result, asynchronous |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read value |
| gie | input | 1 | Global interrupt enable |
| int_ack | input | 1 | Interrupt acknowledge strobe, clears the flag |
| irq | output | 1 | Interrupt request |
| cap_trig | output | 1 | Comparator level routed to the input-capture stage |

## Verification
The bench targets a clear that lands in the same cycle as a new edge. A design that lets the clear win would silently lose that event. It also targets the reserved mode code: a design that treats 01 like toggle, or decodes the rising and falling codes the wrong way round, would set the flag on the wrong transitions. It checks that a write aimed at another field, carrying a 1 in the flag position, still clears the flag, and that disabling the block masks the level bit, edge events and the capture trigger but keeps a flag that was already set. A design that sampled the raw input, or left out a synchronizer stage, would move the level bit and the flag one or more cycles early. The cycle-exact reference model catches that.

// File: rtl/cmpi_pkg.sv
package cmpi_pkg;

  localparam int REG_W = 8;

  localparam int BIT_DIS   = 7;
  localparam int BIT_RSVD  = 6;
  localparam int BIT_LEVEL = 5;
  localparam int BIT_FLAG  = 4;
  localparam int BIT_IE    = 3;
  localparam int BIT_CAP   = 2;
  localparam int BIT_MODE1 = 1;
  localparam int BIT_MODE0 = 0;

  typedef enum logic [1:0] {
    EDGE_ANY  = 2'b00,
    EDGE_RSVD = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_RISE = 2'b11
  } edge_mode_e;

  typedef struct packed {
    logic       dis;
    logic       ie;
    logic       cap;
    edge_mode_e mode;
  } ctrl_t;

endpackage

// File: rtl/cmpi_sync.sv
module cmpi_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[i] <= 1'b0;
          else        chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign sync_out = chain[LAST];

endmodule

// File: rtl/cmpi_edge.sv
module cmpi_edge
  import cmpi_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       level,
  input  edge_mode_e mode,
  input  logic       blocked,
  output logic       event_o
);
  logic prev_q;
  logic rise, fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= level;
  end

  assign rise = level & ~prev_q;
  assign fall = ~level & prev_q;

  always_comb begin
    unique case (mode)
      EDGE_ANY:  event_o = rise | fall;
      EDGE_FALL: event_o = fall;
      EDGE_RISE: event_o = rise;
      default:   event_o = 1'b0;
    endcase
    if (blocked) event_o = 1'b0;
  end

  assert_reserved_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == EDGE_RSVD) |-> !event_o);

  assert_blocked_silent_R11: assert property (@(posedge clk) disable iff (!rst_n)
    blocked |-> !event_o);

  assert_rise_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (event_o && mode == EDGE_RISE) |-> level);

  assert_fall_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (event_o && mode == EDGE_FALL) |-> !level);

endmodule

// File: rtl/cmpi_regs.sv
module cmpi_regs
  import cmpi_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [REG_W-1:0] wdata,
  input  logic             ack,
  input  logic             set_ev,
  output ctrl_t            ctrl,
  output logic             flag
);
  logic clr_req;

  assign clr_req = (wr & wdata[BIT_FLAG]) | ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '{dis: 1'b0, ie: 1'b0, cap: 1'b0, mode: EDGE_ANY};
    end else if (wr) begin
      ctrl.dis  <= wdata[BIT_DIS];
      ctrl.ie   <= wdata[BIT_IE];
      ctrl.cap  <= wdata[BIT_CAP];
      ctrl.mode <= edge_mode_e'({wdata[BIT_MODE1], wdata[BIT_MODE0]});
    end
  end

  // An event wins over a same-cycle clear so it is never lost.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag <= 1'b0;
    else if (set_ev)  flag <= 1'b1;
    else if (clr_req) flag <= 1'b0;
  end

  assert_flag_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(set_ev));

  assert_event_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    set_ev |=> flag);

  assert_w1c_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && wdata[BIT_FLAG] && !set_ev) |=> !flag);

  assert_ack_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !set_ev) |=> !flag);

endmodule

// File: rtl/cmp_irq_ctrl.sv
module cmp_irq_ctrl
  import cmpi_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmp_in,
  input  logic             reg_wr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             gie,
  input  logic             int_ack,
  output logic             irq,
  output logic             cap_trig
);
  logic  level_s;
  logic  edge_ev;
  logic  flag;
  ctrl_t ctrl;

  cmpi_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (cmp_in),
    .sync_out (level_s)
  );

  cmpi_edge u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .level   (level_s),
    .mode    (ctrl.mode),
    .blocked (ctrl.dis),
    .event_o (edge_ev)
  );

  cmpi_regs u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr     (reg_wr),
    .wdata  (reg_wdata),
    .ack    (int_ack),
    .set_ev (edge_ev),
    .ctrl   (ctrl),
    .flag   (flag)
  );

  always_comb begin
    reg_rdata            = '0;
    reg_rdata[BIT_DIS]   = ctrl.dis;
    reg_rdata[BIT_LEVEL] = level_s & ~ctrl.dis;
    reg_rdata[BIT_FLAG]  = flag;
    reg_rdata[BIT_IE]    = ctrl.ie;
    reg_rdata[BIT_CAP]   = ctrl.cap;
    reg_rdata[BIT_MODE1] = ctrl.mode[1];
    reg_rdata[BIT_MODE0] = ctrl.mode[0];
  end

  assign irq      = flag & ctrl.ie & gie;
  assign cap_trig = ctrl.cap & ~ctrl.dis & level_s;

  assert_dis_masks_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.dis |-> (!cap_trig && !reg_rdata[BIT_LEVEL]));

  assert_irq_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (gie && reg_rdata[BIT_FLAG] && reg_rdata[BIT_IE]));

  assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rdata[BIT_RSVD]);

  assert_cap_route_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cap_trig |-> (ctrl.cap && level_s));

endmodule

// File: tb/cmp_irq_ctrl_test.sv
module cmp_irq_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmp_in = 1'b0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       gie = 1'b0;
  logic       int_ack = 1'b0;
  logic       irq;
  logic       cap_trig;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  // reference state
  logic m_s1 = 1'b0, m_s2 = 1'b0, m_prev = 1'b0;
  logic m_dis = 1'b0, m_ie = 1'b0, m_cap = 1'b0, m_flag = 1'b0;
  logic [1:0] m_mode = 2'b00;

  cmp_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .cmp_in(cmp_in), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .gie(gie),
    .int_ack(int_ack), .irq(irq), .cap_trig(cap_trig)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected < %0d", cycles, WATCHDOG);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic logic ev_of(logic [1:0] mode, logic cur, logic prev, logic dis);
    if (dis) return 1'b0;
    case (mode)
      2'b00:   return cur != prev;
      2'b10:   return prev & ~cur;
      2'b11:   return ~prev & cur;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [7:0] exp_rdata();
    return {m_dis, 1'b0, m_s2 & ~m_dis, m_flag, m_ie, m_cap, m_mode};
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    check({tag, " rdata"}, reg_rdata, exp_rdata());
    check({tag, " irq R9"}, {7'd0, irq}, {7'd0, m_flag & m_ie & gie});
    check({tag, " cap_trig R10"}, {7'd0, cap_trig}, {7'd0, m_cap & ~m_dis & m_s2});
  endtask

  // Called just after a falling edge; drives, clocks, models, then checks.
  task automatic step(logic c, logic w, logic [7:0] wd, logic a, logic g, string tag);
    logic ev;
    cmp_in = c; reg_wr = w; reg_wdata = wd; int_ack = a; gie = g;
    ev = ev_of(m_mode, m_s2, m_prev, m_dis);
    @(posedge clk);
    #1;
    if (ev) m_flag = 1'b1;
    else if ((w && wd[4]) || a) m_flag = 1'b0;
    if (w) begin
      m_dis = wd[7]; m_ie = wd[3]; m_cap = wd[2]; m_mode = wd[1:0];
    end
    m_prev = m_s2; m_s2 = m_s1; m_s1 = c;
    @(negedge clk);
    reg_wr = 1'b0; int_ack = 1'b0;
    check_all(tag);
  endtask

  task automatic idle(int n, logic c, string tag);
    for (int i = 0; i < n; i++) step(c, 1'b0, 8'h00, 1'b0, gie, tag);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R1 reset rdata", reg_rdata, 8'h00);
    check("R1 reset irq", {7'd0, irq}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", reg_rdata, 8'h00);
    check("R1 cap_trig", {7'd0, cap_trig}, 8'h00);

    // R3: level seen two edges later; toggle mode flags the change (R4)
    step(1'b0, 1'b1, 8'b0000_1000, 1'b0, 1'b1, "R2 write ie, mode 00");
    step(1'b1, 1'b0, 8'h00, 1'b0, 1'b1, "R3 edge1");
    check("R3 level not yet", {7'd0, reg_rdata[5]}, 8'h00);
    step(1'b1, 1'b0, 8'h00, 1'b0, 1'b1, "R3 edge2");
    check("R3 level after 2 edges", {7'd0, reg_rdata[5]}, 8'h01);
    check("R4 flag not yet", {7'd0, reg_rdata[4]}, 8'h00);
    step(1'b1, 1'b0, 8'h00, 1'b0, 1'b1, "R4 edge3");
    check("R4 toggle flag set", {7'd0, reg_rdata[4]}, 8'h01);
    check("R9 irq raised", {7'd0, irq}, 8'h01);

    // R6: write to other field with bit4 set clears flag; R12 bits 6,5 ignored
    step(1'b1, 1'b1, 8'b0111_1011, 1'b0, 1'b1, "R6 w1c with mode 11");
    check("R6 flag cleared", {7'd0, reg_rdata[4]}, 8'h00);
    check("R12 bit6 reads 0, bit5 follows level", reg_rdata[6:5], 2'b01);

    // rising mode: falling edge must not flag (R4)
    idle(4, 1'b0, "R4 rise mode ignores fall");
    check("R4 no flag on fall in rise mode", {7'd0, reg_rdata[4]}, 8'h00);
    idle(4, 1'b1, "R4 rise mode flags rise");
    check("R4 flag on rise", {7'd0, reg_rdata[4]}, 8'h01);

    // R7: ack clears
    step(1'b1, 1'b0, 8'h00, 1'b1, 1'b1, "R7 ack");
    check("R7 ack cleared flag", {7'd0, reg_rdata[4]}, 8'h00);

    // R5: reserved mode
    step(1'b1, 1'b1, 8'b0000_1001, 1'b0, 1'b1, "R5 mode 01");
    idle(4, 1'b0, "R5 rsvd fall");
    idle(4, 1'b1, "R5 rsvd rise");
    check("R5 reserved never flags", {7'd0, reg_rdata[4]}, 8'h00);

    // falling mode + R8 same-cycle clear
    step(1'b1, 1'b1, 8'b0000_1010, 1'b0, 1'b1, "R4 mode 10");
    step(1'b0, 1'b0, 8'h00, 1'b0, 1'b1, "R8 a");
    step(1'b0, 1'b0, 8'h00, 1'b0, 1'b1, "R8 b");
    step(1'b0, 1'b0, 8'h00, 1'b1, 1'b1, "R8 ack with event");
    check("R8 event beats clear", {7'd0, reg_rdata[4]}, 8'h01);
    step(1'b0, 1'b0, 8'h00, 1'b0, 1'b0, "R9 gie low");
    check("R9 gie masks irq", {7'd0, irq}, 8'h00);

    // R10 capture, R11 disable keeps flag
    step(1'b0, 1'b1, 8'b0000_0110, 1'b0, 1'b1, "R10 cap on");
    idle(3, 1'b1, "R10 cap follows");
    check("R10 cap_trig high", {7'd0, cap_trig}, 8'h01);
    step(1'b1, 1'b1, 8'b1000_0100, 1'b0, 1'b1, "R11 disable");
    check("R11 level masked", {7'd0, reg_rdata[5]}, 8'h00);
    check("R11 cap low", {7'd0, cap_trig}, 8'h00);
    check("R11 flag held", {7'd0, reg_rdata[4]}, 8'h01);
    idle(4, 1'b0, "R11 no event while disabled");

    // random phase
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      r = $urandom;
      step(r[0] ^ (r[7:5] == 3'd0), r[10:8] == 3'd0, r[23:16],
           r[13:11] == 3'd0, r[14], "R4 random");
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule